// File: doc/BRIEF.md
# Multi-Level DMA Channel Arbiter

This block decides which of a parameterised number of DMA channels is serviced next. Every clock cycle it looks at the vector of pending channel requests and picks at most one winner. Each channel is placed in one of four priority levels by a 2-bit field. A request in a higher enabled level always beats any request in a lower level.

Inside a level, the winner is chosen in one of two ways. Static selection gives the win to the lowest channel number. Round-robin selection starts the search just above the channel the level granted last and wraps around. A 4-bit mode mask picks the scheme for each level on its own. A 4-bit enable mask can switch whole levels off. Both masks are held in registers that load on a configuration write strobe.

The result is registered. It consists of a valid flag, a one-hot grant vector and the binary index of the granted channel. The block does not move any data and has no bus interface.

Top module: `chan_prio_arbiter`

## Requirements
- R1: After reset no grant is issued, all four levels are enabled, every level uses static selection, and every level's round-robin pointer is NUM_CH-1, so the first round-robin search starts at channel 0.
- R2: Channel c takes its level from chanLevel[2c+1:2c]. Level 3 is the highest and level 0 the lowest. A pending request in a higher enabled level always wins over any request in a lower level.
- R3: When a level uses static selection (mode bit = 0), the lowest-numbered requesting channel in that level wins.
- R4: When a level's bit in cfgRrMask is 1, that level uses round-robin selection. The search starts at the channel one above the level's pointer and wraps from NUM_CH-1 to 0. Each round-robin grant loads the granted channel into that level's pointer.
- R5: A level's round-robin pointer changes only in a cycle where that level wins the grant. Grants to other levels leave it untouched.
- R6: A level whose bit in the enable mask is 0 is ignored. Its requests never produce a grant, and lower levels are arbitrated as if it were absent.
- R7: When no request is pending in an enabled level, grantValid is 0, grantOneHot is all zeros and grantIdx is 0.
- R8: While grantValid is 1, grantOneHot has exactly bit grantIdx set, and that channel was requesting in the cycle that produced the grant.
- R9: The outputs show the arbitration of the requests present at the previous clock edge. A configuration write (cfgWr = 1) loads cfgLevelEn and cfgRrMask at an edge. The new values govern arbitration from the next edge onward, and the edge of the write itself still uses the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Loads the level enable and mode masks |
| cfgLevelEn | input | 4 | Level enable mask, bit l enables level l |
| cfgRrMask | input | 4 | Mode mask, bit l selects round-robin for level l |
| reqVec | input | NUM_CH | Pending request per channel |
| chanLevel | input | 2*NUM_CH | Priority level of each channel, 2 bits per channel |
| grantValid | output | 1 | A grant was issued this cycle |
| grantOneHot | output | NUM_CH | One-hot grant vector |
| grantIdx | output | $clog2(NUM_CH) | Index of the granted channel |

## Verification
A grant shows up one clock edge after the requests that produced it. A configuration write governs arbitration only from the edge after the write. The bench therefore drives each stimulus on a falling edge and lets one rising edge pass. It then reads the outputs on the following falling edge, before it drives the next stimulus. The round-robin rows of the table depend on the pointer state built up by earlier rows, so the table is walked strictly in order. Dedicated cases cover the same-edge configuration write and a single-cycle request pulse, each checked over two consecutive falling edges.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned LEVELS = 4;
  localparam int unsigned LVL_W  = 2;

  // Strobes issued by control toward the datapath each cycle
  typedef struct packed {
    logic              capture;  // register the current winner
    logic              clear;    // register an idle result
    logic [LEVELS-1:0] bump;     // round-robin pointer update per level
  } arb_strobe_t;
endpackage

// File: rtl/arb_level_pick.sv
module arb_level_pick #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned LEVEL  = 0
) (
  input  logic [NUM_CH-1:0]   reqVec,
  input  logic [2*NUM_CH-1:0] chanLevel,
  input  logic                levelOn,
  input  logic                rrOn,
  input  logic [IDX_W-1:0]    lastPtr,
  output logic                hit,
  output logic [IDX_W-1:0]    pick
);
  logic [NUM_CH-1:0] mine;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_member
      assign mine[c] = levelOn && reqVec[c] &&
                       (chanLevel[2*c +: 2] == 2'(LEVEL));
    end
  endgenerate

  // Circular first-set search; static mode starts at channel 0
  always_comb begin
    int startPos;
    logic found;
    found = 1'b0;
    pick  = '0;
    hit   = |mine;
    startPos = rrOn ? ((int'(lastPtr) + 1) % int'(NUM_CH)) : 0;
    for (int k = 0; k < int'(NUM_CH); k++) begin
      int pos;
      pos = (startPos + k) % int'(NUM_CH);
      if (!found && mine[pos]) begin
        pick  = IDX_W'(pos);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     reqVec,
  input  logic [2*NUM_CH-1:0]   chanLevel,
  input  logic [LEVELS-1:0]     lvlEn,
  input  logic [LEVELS-1:0]     rrMode,
  input  logic [LEVELS*IDX_W-1:0] ptrFlat,
  input  arb_strobe_t           strobe,
  output logic                  winAny,
  output logic [LVL_W-1:0]      winLevel,
  output logic [IDX_W-1:0]      winIdx,
  output logic                  grantValid,
  output logic [NUM_CH-1:0]     grantOneHot,
  output logic [IDX_W-1:0]      grantIdx
);
  logic [LEVELS-1:0] lvlHit;
  logic [IDX_W-1:0]  lvlPick [LEVELS];

  genvar l;
  generate
    for (l = 0; l < LEVELS; l++) begin : g_level
      arb_level_pick #(
        .NUM_CH(NUM_CH), .IDX_W(IDX_W), .LEVEL(l)
      ) u_pick (
        .reqVec   (reqVec),
        .chanLevel(chanLevel),
        .levelOn  (lvlEn[l]),
        .rrOn     (rrMode[l]),
        .lastPtr  (ptrFlat[l*IDX_W +: IDX_W]),
        .hit      (lvlHit[l]),
        .pick     (lvlPick[l])
      );
    end
  endgenerate

  // Higher level overrides lower: the last hit in ascending order stands
  always_comb begin
    winAny   = 1'b0;
    winLevel = '0;
    winIdx   = '0;
    for (int k = 0; k < int'(LEVELS); k++) begin
      if (lvlHit[k]) begin
        winAny   = 1'b1;
        winLevel = LVL_W'(k);
        winIdx   = lvlPick[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clear) begin
      grantValid  <= 1'b0;
      grantOneHot <= '0;
      grantIdx    <= '0;
    end else if (strobe.capture) begin
      grantValid  <= 1'b1;
      grantOneHot <= NUM_CH'(1) << winIdx;
      grantIdx    <= winIdx;
    end
  end
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfgWr,
  input  logic [LEVELS-1:0]       cfgLevelEn,
  input  logic [LEVELS-1:0]       cfgRrMask,
  input  logic                    winAny,
  input  logic [LVL_W-1:0]        winLevel,
  input  logic [IDX_W-1:0]        winIdx,
  output logic [LEVELS-1:0]       lvlEnQ,
  output logic [LEVELS-1:0]       rrModeQ,
  output logic [LEVELS*IDX_W-1:0] ptrFlat,
  output arb_strobe_t             strobe
);
  localparam logic [IDX_W-1:0] PTR_INIT = IDX_W'(NUM_CH - 1);

  logic [IDX_W-1:0] ptrQ [LEVELS];

  always_comb begin
    strobe.capture = winAny;
    strobe.clear   = !winAny;
    for (int k = 0; k < int'(LEVELS); k++)
      strobe.bump[k] = winAny && (winLevel == LVL_W'(k)) && rrModeQ[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvlEnQ  <= '1;
      rrModeQ <= '0;
    end else if (cfgWr) begin
      lvlEnQ  <= cfgLevelEn;
      rrModeQ <= cfgRrMask;
    end
  end

  genvar l;
  generate
    for (l = 0; l < LEVELS; l++) begin : g_ptr
      always_ff @(posedge clk) begin
        if (!rst_n)
          ptrQ[l] <= PTR_INIT;
        else if (strobe.bump[l])
          ptrQ[l] <= winIdx;
      end
      assign ptrFlat[l*IDX_W +: IDX_W] = ptrQ[l];
    end
  endgenerate
endmodule

// File: rtl/chan_prio_arbiter.sv
module chan_prio_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfgWr,
  input  logic [LEVELS-1:0]   cfgLevelEn,
  input  logic [LEVELS-1:0]   cfgRrMask,
  input  logic [NUM_CH-1:0]   reqVec,
  input  logic [2*NUM_CH-1:0] chanLevel,
  output logic                grantValid,
  output logic [NUM_CH-1:0]   grantOneHot,
  output logic [IDX_W-1:0]    grantIdx
);
  logic [LEVELS-1:0]       lvlEnQ;
  logic [LEVELS-1:0]       rrModeQ;
  logic [LEVELS*IDX_W-1:0] ptrFlat;
  arb_strobe_t             strobe;
  logic                    winAny;
  logic [LVL_W-1:0]        winLevel;
  logic [IDX_W-1:0]        winIdx;

  arb_ctrl #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfgWr(cfgWr), .cfgLevelEn(cfgLevelEn), .cfgRrMask(cfgRrMask),
    .winAny(winAny), .winLevel(winLevel), .winIdx(winIdx),
    .lvlEnQ(lvlEnQ), .rrModeQ(rrModeQ), .ptrFlat(ptrFlat), .strobe(strobe)
  );

  arb_datapath #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .reqVec(reqVec), .chanLevel(chanLevel),
    .lvlEn(lvlEnQ), .rrMode(rrModeQ), .ptrFlat(ptrFlat), .strobe(strobe),
    .winAny(winAny), .winLevel(winLevel), .winIdx(winIdx),
    .grantValid(grantValid), .grantOneHot(grantOneHot), .grantIdx(grantIdx)
  );
endmodule

// File: rtl/chan_prio_arbiter_checker.sv
module chan_prio_arbiter_checker #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned IDX_W  = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_CH-1:0]   reqVec,
  input logic [2*NUM_CH-1:0] chanLevel,
  input logic [3:0]          lvlEnQ,
  input logic                grantValid,
  input logic [NUM_CH-1:0]   grantOneHot,
  input logic [IDX_W-1:0]    grantIdx
);
  logic [NUM_CH-1:0]   prevReq;
  logic [2*NUM_CH-1:0] prevLv;
  logic [3:0]          prevEn;
  logic [1:0]          grantLvl;
  logic                higherPending;

  always_ff @(posedge clk) begin
    prevReq <= reqVec;
    prevLv  <= chanLevel;
    prevEn  <= lvlEnQ;
  end

  always_comb begin
    grantLvl = prevLv[2*grantIdx +: 2];
    higherPending = 1'b0;
    for (int c = 0; c < int'(NUM_CH); c++)
      if (prevReq[c] && prevEn[prevLv[2*c +: 2]] && (prevLv[2*c +: 2] > grantLvl))
        higherPending = 1'b1;
  end

  p_onehot_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid |-> (grantOneHot == (NUM_CH'(1) << grantIdx)));

  p_was_requested_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid |-> ((prevReq & grantOneHot) != '0));

  p_idle_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !grantValid |-> (grantOneHot == '0 && grantIdx == '0));

  p_no_req_no_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reqVec) == '0 |-> !grantValid);

  p_enabled_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid |-> prevEn[grantLvl]);

  p_highest_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid |-> !higherPending);

  p_grant_onehot0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grantOneHot));
endmodule

bind chan_prio_arbiter chan_prio_arbiter_checker #(
  .NUM_CH(NUM_CH), .IDX_W(IDX_W)
) u_checker (
  .clk(clk), .rst_n(rst_n), .reqVec(reqVec), .chanLevel(chanLevel),
  .lvlEnQ(lvlEnQ), .grantValid(grantValid), .grantOneHot(grantOneHot),
  .grantIdx(grantIdx)
);

// File: tb/chan_prio_arbiter_bench.sv
`timescale 1ns/1ps
module chan_prio_arbiter_bench;
  localparam int NCH = 8;
  localparam int IW  = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfgWr = 1'b0;
  logic [3:0]     cfgLevelEn = 4'hF;
  logic [3:0]     cfgRrMask = 4'h0;
  logic [NCH-1:0] reqVec = '0;
  logic [2*NCH-1:0] chanLevel = '0;
  logic           grantValid;
  logic [NCH-1:0] grantOneHot;
  logic [IW-1:0]  grantIdx;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  chan_prio_arbiter #(.NUM_CH(NCH)) u_chan_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .cfgWr(cfgWr), .cfgLevelEn(cfgLevelEn),
    .cfgRrMask(cfgRrMask), .reqVec(reqVec), .chanLevel(chanLevel),
    .grantValid(grantValid), .grantOneHot(grantOneHot), .grantIdx(grantIdx)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [15:0] lv;
    logic        wr;
    logic [3:0]  en;
    logic [3:0]  rr;
    logic        ev;
    logic [2:0]  ei;
    logic [3:0]  tag;
  } row_t;

  localparam int NROWS = 25;
  localparam row_t TBL [NROWS] = '{
    '{8'h00, 16'h0000, 1'b0, 4'hF, 4'h0, 1'b0, 3'd0, 4'd7}, // R7 idle
    '{8'h06, 16'h0000, 1'b0, 4'hF, 4'h0, 1'b1, 3'd1, 4'd3}, // R3 lowest
    '{8'h81, 16'h0000, 1'b0, 4'hF, 4'h0, 1'b1, 3'd0, 4'd3}, // R3
    '{8'h25, 16'h0C10, 1'b0, 4'hF, 4'h0, 1'b1, 3'd5, 4'd2}, // R2 level3 wins
    '{8'h05, 16'h0C10, 1'b0, 4'hF, 4'h0, 1'b1, 3'd2, 4'd2}, // R2 level1 over 0
    '{8'h00, 16'h0C10, 1'b1, 4'hD, 4'h0, 1'b0, 3'd0, 4'd6}, // R6 disable lvl1
    '{8'h04, 16'h0C10, 1'b0, 4'hD, 4'h0, 1'b0, 3'd0, 4'd6}, // R6 ignored
    '{8'h05, 16'h0C10, 1'b0, 4'hD, 4'h0, 1'b1, 3'd0, 4'd6}, // R6 lower still arbitrated
    '{8'h00, 16'h0000, 1'b1, 4'hF, 4'h1, 1'b0, 3'd0, 4'd4}, // R4 lvl0 round-robin
    '{8'h0F, 16'h0000, 1'b0, 4'hF, 4'h1, 1'b1, 3'd0, 4'd4}, // R4 start at 0
    '{8'h0F, 16'h0000, 1'b0, 4'hF, 4'h1, 1'b1, 3'd1, 4'd4}, // R4
    '{8'h0F, 16'h0000, 1'b0, 4'hF, 4'h1, 1'b1, 3'd2, 4'd4}, // R4
    '{8'h0F, 16'h0000, 1'b0, 4'hF, 4'h1, 1'b1, 3'd3, 4'd4}, // R4
    '{8'h0F, 16'h0000, 1'b0, 4'hF, 4'h1, 1'b1, 3'd0, 4'd4}, // R4 wrap
    '{8'h81, 16'h0000, 1'b0, 4'hF, 4'h1, 1'b1, 3'd7, 4'd4}, // R4 skip gap
    '{8'h81, 16'h0000, 1'b0, 4'hF, 4'h1, 1'b1, 3'd0, 4'd4}, // R4 wrap past top
    '{8'h00, 16'h0000, 1'b1, 4'hF, 4'h3, 1'b0, 3'd0, 4'd5}, // R5 lvl0+lvl1 rr
    '{8'hFF, 16'h5500, 1'b0, 4'hF, 4'h3, 1'b1, 3'd4, 4'd5}, // R5 lvl1 wins
    '{8'h0F, 16'h5500, 1'b0, 4'hF, 4'h3, 1'b1, 3'd1, 4'd5}, // R5 lvl0 pointer held
    '{8'hFF, 16'h5500, 1'b0, 4'hF, 4'h3, 1'b1, 3'd5, 4'd5}, // R5
    '{8'h0E, 16'h5500, 1'b0, 4'hF, 4'h3, 1'b1, 3'd2, 4'd5}, // R5
    '{8'h00, 16'h5500, 1'b1, 4'hF, 4'h0, 1'b0, 3'd0, 4'd3}, // R3 back to static
    '{8'hF0, 16'h5500, 1'b0, 4'hF, 4'h0, 1'b1, 3'd4, 4'd3}, // R3
    '{8'h00, 16'h5500, 1'b1, 4'h0, 4'h0, 1'b0, 3'd0, 4'd6}, // R6 all off
    '{8'hFF, 16'h5500, 1'b0, 4'h0, 4'h0, 1'b0, 3'd0, 4'd6}  // R6 nothing granted
  };

  task automatic check(input logic ev, input logic [2:0] ei, input string tag);
    logic [NCH-1:0] eoh;
    eoh = ev ? (NCH'(1) << ei) : '0;
    checks++;
    if (grantValid !== ev || grantOneHot !== eoh || grantIdx !== (ev ? ei : 3'd0)) begin
      errors++;
      $display("FAIL %s: valid=%0b idx=%0d onehot=%b expected valid=%0b idx=%0d onehot=%b",
               tag, grantValid, grantIdx, grantOneHot, ev, ev ? ei : 3'd0, eoh);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, 3'd0, "R1 reset idle");

    // Table walk: drive on a falling edge, check on the next falling edge
    for (int i = 0; i < NROWS; i++) begin
      reqVec = TBL[i].req; chanLevel = TBL[i].lv; cfgWr = TBL[i].wr;
      cfgLevelEn = TBL[i].en; cfgRrMask = TBL[i].rr;
      @(negedge clk);
      check(TBL[i].ev, TBL[i].ei, $sformatf("R%0d row %0d", TBL[i].tag, i));
    end
    cfgWr = 1'b0;

    // R1: reset restores enables, static mode and pointers
    reqVec = 8'h0C; chanLevel = '0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(1'b1, 3'd2, "R1 enabled and static after reset");

    // R9: write at the same edge as arbitration uses the old enables
    reqVec = 8'h01; cfgWr = 1'b1; cfgLevelEn = 4'h0; cfgRrMask = 4'h0;
    @(negedge clk);
    check(1'b1, 3'd0, "R9 write edge uses old config");
    cfgWr = 1'b0;
    @(negedge clk);
    check(1'b0, 3'd0, "R9 new config next edge");

    // R9: single-cycle request pulse appears one edge later, then idle
    cfgWr = 1'b1; cfgLevelEn = 4'hF; reqVec = '0;
    @(negedge clk);
    cfgWr = 1'b0; reqVec = 8'h10;
    @(negedge clk);
    check(1'b1, 3'd4, "R9 pulse granted");
    reqVec = '0;
    @(negedge clk);
    check(1'b0, 3'd0, "R7 pulse gone");

    // R8: mixed levels, level 2 alone beats lower requests
    chanLevel = 16'h0200; reqVec = 8'h13;
    @(negedge clk);
    check(1'b1, 3'd4, "R8 level2 grant");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    finished = 1'b1;
    $finish;
  end
endmodule